// File: doc/BRIEF.md
# Sequential Integer Multiply/Divide Unit

This block is a shared, non-pipelined arithmetic engine for integer multiplication and division. It handles both 32-bit (word) and 64-bit (doubleword) operands, in signed or unsigned form. A request is taken only while the unit is idle. The unit then stays busy for a fixed number of cycles. That number depends on the operation and the width, not on the operand values. When the busy period ends, the result lands in two dedicated result registers, `hi` and `lo`.

A consumer that wants to read `hi`/`lo` raises `rd_req`. If a computation is still running, the unit answers with `stall` until the result is in place. While it is busy, the unit refuses any further request. The issuing side sees this through `req_ready`, and a refused request is simply lost. It is not queued.

The iterative datapaths inside, a radix-16 multiplier and a one-bit-per-cycle restoring divider, finish ahead of the published latency. The results are released only when the fixed latency counter expires. This keeps the timing identical for every operand, including a zero divisor.

Top module: `md_unit`

## Requirements
- R1: While idle, `req_ready` is 1. A request with `req_valid`=1 is accepted at the next rising edge, and `busy` is 1 in the following cycle.
- R2: After an accepted request, `busy` stays 1 for exactly 10 cycles for a word multiply, 20 for a doubleword multiply, 69 for a word divide and 133 for a doubleword divide. The encoding is `req_div`=1 for divide and `req_dword`=1 for 64-bit.
- R3: While `busy` is 1, `req_ready` is 0. A request presented then changes neither the result nor the length of the current operation, and it is not started afterwards.
- R4: `stall` is 1 exactly when `rd_req` is 1 while `busy` is 1. It is 0 once the result is available.
- R5: A multiply writes the upper half of the product to `hi` and the lower half to `lo`. For a word operation only operand bits [31:0] are used, and each 32-bit half is sign-extended from its bit 31 to 64 bits.
- R6: A divide writes the quotient to `lo` and the remainder to `hi`. Signed division truncates toward zero, and the remainder takes the sign of the dividend. Word results are sign-extended from bit 31.
- R7: `req_signed`=1 treats the operands as two's complement. `req_signed`=0 treats them as unsigned.
- R8: A divide by zero takes the normal divide latency and raises no trap. In unsigned form it leaves all ones in `lo` and the dividend in `hi` (for word mode, dividend bits [31:0] sign-extended).
- R9: After reset, `busy`, `hi` and `lo` are 0. `hi`/`lo` hold their values until the next operation completes.
- R10: A signed divide of the most negative value by -1 returns that most negative value in `lo` and 0 in `hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request to start an operation |
| req_div | input | 1 | 1 = divide, 0 = multiply |
| req_signed | input | 1 | 1 = signed operands |
| req_dword | input | 1 | 1 = 64-bit, 0 = 32-bit |
| req_a | input | 64 | Multiplicand or dividend |
| req_b | input | 64 | Multiplier or divisor |
| req_ready | output | 1 | Unit idle, request would be accepted |
| busy | output | 1 | Operation in progress |
| rd_req | input | 1 | Consumer wants to read hi/lo |
| stall | output | 1 | Read must wait for the result |
| hi | output | 64 | Upper product half or remainder |
| lo | output | 64 | Lower product half or quotient |

## Verification
A refused request and a stalled result read can fall in the same cycle, and either can coincide with a running operation's countdown. The bench provokes this in every operation. Two cycles after acceptance it raises `req_valid` with a different operation and different operands, together with `rd_req`. It then checks that `stall` is 1 and `req_ready` is 0 at that moment. Finally it checks that the busy period keeps its exact length, that the result matches the original request, and that `busy` does not come back afterwards.

// File: rtl/md_pkg.sv
package md_pkg;
  // operation kind: bit 1 = divide, bit 0 = doubleword
  typedef enum logic [1:0] {
    MD_MUL_W = 2'b00,
    MD_MUL_D = 2'b01,
    MD_DIV_W = 2'b10,
    MD_DIV_D = 2'b11
  } md_kind_e;

  typedef struct packed {
    logic is_div;
    logic is_dword;
    logic neg_main;  // negate product / quotient
    logic neg_rem;   // negate remainder
  } md_ctl_t;
endpackage

// File: rtl/md_rst_sync.sv
module md_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/md_sequencer.sv
module md_sequencer
  import md_pkg::*;
#(
  parameter int MUL_LAT_W = 10,
  parameter int MUL_LAT_D = 20,
  parameter int DIV_LAT_W = 69,
  parameter int DIV_LAT_D = 133
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  md_kind_e kind,
  output logic     accept,
  output logic     commit,
  output logic     busy
);
  localparam int MAX_MUL = (MUL_LAT_W > MUL_LAT_D) ? MUL_LAT_W : MUL_LAT_D;
  localparam int MAX_DIV = (DIV_LAT_W > DIV_LAT_D) ? DIV_LAT_W : DIV_LAT_D;
  localparam int MAX_LAT = (MAX_MUL > MAX_DIV) ? MAX_MUL : MAX_DIV;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, lat_sel;
  logic             cnt_en;

  always_comb begin
    unique case (kind)
      MD_MUL_W: lat_sel = CNT_W'(MUL_LAT_W);
      MD_MUL_D: lat_sel = CNT_W'(MUL_LAT_D);
      MD_DIV_W: lat_sel = CNT_W'(DIV_LAT_W);
      default:  lat_sel = CNT_W'(DIV_LAT_D);
    endcase
  end

  assign busy   = (cnt_q != '0);
  assign accept = req_valid && !busy;
  assign commit = (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_en = accept || busy;
    cnt_d  = accept ? lat_sel : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/md_mul_core.sv
module md_mul_core #(
  parameter int XLEN = 64,
  parameter int STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              half,
  input  logic [XLEN-1:0]   a_mag,
  input  logic [XLEN-1:0]   b_mag,
  output logic [2*XLEN-1:0] prod,
  output logic              done
);
  localparam int PW    = 2 * XLEN;
  localparam int HALF  = XLEN / 2;
  localparam int NFULL = XLEN / STEP;
  localparam int NHALF = NFULL / 2;
  localparam int SCW   = $clog2(NFULL + 1);
  localparam int SW    = XLEN + STEP;

  logic [PW-1:0]   p_q, p_d;
  logic [XLEN-1:0] a_q;
  logic            half_q;
  logic [SCW-1:0]  left_q, left_d;
  logic            run_en;
  logic [SW-1:0]   partial, sum;

  // one radix-2^STEP digit of the multiplier per cycle
  always_comb begin
    partial = {{STEP{1'b0}}, a_q} * {{XLEN{1'b0}}, p_q[STEP-1:0]};
    sum     = {{STEP{1'b0}}, p_q[PW-1:XLEN]} + partial;
  end

  always_comb begin
    run_en = start || (left_q != '0);
    if (start) begin
      p_d    = {{XLEN{1'b0}}, b_mag};
      left_d = half ? SCW'(NHALF) : SCW'(NFULL);
    end else begin
      p_d    = {sum, p_q[XLEN-1:STEP]};
      left_d = left_q - SCW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q    <= '0;
      left_q <= '0;
    end else if (run_en) begin
      p_q    <= p_d;
      left_q <= left_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      half_q <= 1'b0;
    end else if (start) begin
      a_q    <= a_mag;
      half_q <= half;
    end
  end

  // word mode stops after half the digits: product sits one half-word up
  assign prod = half_q ? {{XLEN{1'b0}}, p_q[XLEN+HALF-1:HALF]} : p_q;
  assign done = (left_q == '0);
endmodule

// File: rtl/md_div_core.sv
module md_div_core #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            half,
  input  logic [XLEN-1:0] num_mag,
  input  logic [XLEN-1:0] den_mag,
  output logic [XLEN-1:0] quo,
  output logic [XLEN-1:0] rem,
  output logic            done
);
  localparam int HALF = XLEN / 2;
  localparam int CW   = $clog2(XLEN + 1);

  logic [XLEN-1:0] q_q, q_d, r_q, r_d, d_q;
  logic [CW-1:0]   left_q, left_d;
  logic [XLEN:0]   trial, diff;
  logic            fits, run_en;

  // restoring step: shift in the next dividend bit, subtract when it fits
  always_comb begin
    trial = {r_q, q_q[XLEN-1]};
    diff  = trial - {1'b0, d_q};
    fits  = (trial >= {1'b0, d_q});
  end

  always_comb begin
    run_en = start || (left_q != '0);
    if (start) begin
      q_d    = half ? (num_mag << HALF) : num_mag;
      r_d    = '0;
      left_d = half ? CW'(HALF) : CW'(XLEN);
    end else begin
      q_d    = {q_q[XLEN-2:0], fits};
      r_d    = fits ? diff[XLEN-1:0] : trial[XLEN-1:0];
      left_d = left_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q    <= '0;
      r_q    <= '0;
      left_q <= '0;
    end else if (run_en) begin
      q_q    <= q_d;
      r_q    <= r_d;
      left_q <= left_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     d_q <= '0;
    else if (start) d_q <= den_mag;
  end

  assign quo  = q_q;
  assign rem  = r_q;
  assign done = (left_q == '0);
endmodule

// File: rtl/md_unit.sv
module md_unit
  import md_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int MUL_STEP  = 4,
  parameter int MUL_LAT_W = 10,
  parameter int MUL_LAT_D = 20,
  parameter int DIV_LAT_W = 69,
  parameter int DIV_LAT_D = 133
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_div,
  input  logic            req_signed,
  input  logic            req_dword,
  input  logic [XLEN-1:0] req_a,
  input  logic [XLEN-1:0] req_b,
  output logic            req_ready,
  output logic            busy,
  input  logic            rd_req,
  output logic            stall,
  output logic [XLEN-1:0] hi,
  output logic [XLEN-1:0] lo
);
  localparam int HALF = XLEN / 2;
  localparam int PW   = 2 * XLEN;

  logic core_rst_n;
  logic accept, commit;
  logic mul_done, div_done;
  md_kind_e kind;

  md_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n_async(rst_n), .rst_n_sync(core_rst_n)
  );

  assign kind = md_kind_e'({req_div, req_dword});

  md_sequencer #(
    .MUL_LAT_W(MUL_LAT_W), .MUL_LAT_D(MUL_LAT_D),
    .DIV_LAT_W(DIV_LAT_W), .DIV_LAT_D(DIV_LAT_D)
  ) u_seq (
    .clk(clk), .rst_n(core_rst_n), .req_valid(req_valid), .kind(kind),
    .accept(accept), .commit(commit), .busy(busy)
  );

  // ---------------- operand conditioning ----------------
  logic [XLEN-1:0] a_sx, b_sx, a_abs, b_abs, a_mag, b_mag;
  logic            a_neg, b_neg;

  always_comb begin
    a_sx  = req_dword ? req_a : {{HALF{req_a[HALF-1]}}, req_a[HALF-1:0]};
    b_sx  = req_dword ? req_b : {{HALF{req_b[HALF-1]}}, req_b[HALF-1:0]};
    a_neg = req_signed && a_sx[XLEN-1];
    b_neg = req_signed && b_sx[XLEN-1];
    a_abs = a_neg ? -a_sx : a_sx;
    b_abs = b_neg ? -b_sx : b_sx;
    a_mag = req_dword ? a_abs : {{HALF{1'b0}}, a_abs[HALF-1:0]};
    b_mag = req_dword ? b_abs : {{HALF{1'b0}}, b_abs[HALF-1:0]};
  end

  md_ctl_t ctl_q, ctl_d;

  always_comb begin
    ctl_d.is_div   = req_div;
    ctl_d.is_dword = req_dword;
    ctl_d.neg_main = a_neg ^ b_neg;
    ctl_d.neg_rem  = a_neg;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)  ctl_q <= '0;
    else if (accept)  ctl_q <= ctl_d;
  end

  // ---------------- engines ----------------
  logic [PW-1:0]   prod;
  logic [XLEN-1:0] quo, rem;

  md_mul_core #(.XLEN(XLEN), .STEP(MUL_STEP)) u_mul (
    .clk(clk), .rst_n(core_rst_n), .start(accept && !req_div),
    .half(!req_dword), .a_mag(a_mag), .b_mag(b_mag),
    .prod(prod), .done(mul_done)
  );

  md_div_core #(.XLEN(XLEN)) u_div (
    .clk(clk), .rst_n(core_rst_n), .start(accept && req_div),
    .half(!req_dword), .num_mag(a_mag), .den_mag(b_mag),
    .quo(quo), .rem(rem), .done(div_done)
  );

  // ---------------- result formatting ----------------
  logic [PW-1:0]   prod_s;
  logic [XLEN-1:0] quo_s, rem_s, hi_d, lo_d;

  always_comb begin
    prod_s = ctl_q.neg_main ? -prod : prod;
    quo_s  = ctl_q.neg_main ? -quo  : quo;
    rem_s  = ctl_q.neg_rem  ? -rem  : rem;
    unique case ({ctl_q.is_div, ctl_q.is_dword})
      2'b00: begin
        hi_d = {{HALF{prod_s[XLEN-1]}}, prod_s[XLEN-1:HALF]};
        lo_d = {{HALF{prod_s[HALF-1]}}, prod_s[HALF-1:0]};
      end
      2'b01: begin
        hi_d = prod_s[PW-1:XLEN];
        lo_d = prod_s[XLEN-1:0];
      end
      2'b10: begin
        hi_d = {{HALF{rem_s[HALF-1]}}, rem_s[HALF-1:0]};
        lo_d = {{HALF{quo_s[HALF-1]}}, quo_s[HALF-1:0]};
      end
      default: begin
        hi_d = rem_s;
        lo_d = quo_s;
      end
    endcase
  end

  logic [XLEN-1:0] hi_q, lo_q;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (commit) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign hi        = hi_q;
  assign lo        = lo_q;
  assign req_ready = !busy;
  assign stall     = rd_req && busy;
endmodule

// File: rtl/md_unit_checker.sv
module md_unit_checker #(
  parameter int XLEN      = 64,
  parameter int MUL_LAT_W = 10,
  parameter int MUL_LAT_D = 20,
  parameter int DIV_LAT_W = 69,
  parameter int DIV_LAT_D = 133
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_div,
  input logic            req_dword,
  input logic            req_ready,
  input logic            busy,
  input logic            stall,
  input logic            mul_done,
  input logic            div_done,
  input logic            commit,
  input logic [XLEN-1:0] hi,
  input logic [XLEN-1:0] lo
);
  localparam int AW = 10;

  logic [AW-1:0] age_q, lat_q;
  logic [AW-1:0] lat_pick;

  always_comb begin
    case ({req_div, req_dword})
      2'b00:   lat_pick = AW'(MUL_LAT_W);
      2'b01:   lat_pick = AW'(MUL_LAT_D);
      2'b10:   lat_pick = AW'(DIV_LAT_W);
      default: lat_pick = AW'(DIV_LAT_D);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
      lat_q <= '0;
    end else if (req_valid && !busy) begin
      age_q <= AW'(1);
      lat_q <= lat_pick;
    end else if (busy) begin
      age_q <= age_q + AW'(1);
    end
  end

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy |=> busy);

  assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (age_q < lat_q) |=> busy);

  assert_busy_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (age_q == lat_q) |=> !busy);

  assert_refuse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  assert_stall_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !stall);

  assert_engine_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> mul_done && div_done);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(hi) && $stable(lo));
endmodule

bind md_unit md_unit_checker #(
  .XLEN(XLEN),
  .MUL_LAT_W(MUL_LAT_W), .MUL_LAT_D(MUL_LAT_D),
  .DIV_LAT_W(DIV_LAT_W), .DIV_LAT_D(DIV_LAT_D)
) u_md_chk (
  .clk(clk), .rst_n(core_rst_n), .req_valid(req_valid), .req_div(req_div),
  .req_dword(req_dword), .req_ready(req_ready), .busy(busy), .stall(stall),
  .mul_done(mul_done), .div_done(div_done), .commit(commit),
  .hi(hi), .lo(lo)
);

// File: tb/md_unit_bench.sv
module md_unit_bench;
  logic        clk;
  logic        rst_n;
  logic        req_valid, req_div, req_signed, req_dword;
  logic [63:0] req_a, req_b;
  logic        req_ready, busy, rd_req, stall;
  logic [63:0] hi, lo;

  int vectors     = 0;
  int miscompares = 0;

  md_unit u_md_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_div(req_div),
    .req_signed(req_signed), .req_dword(req_dword), .req_a(req_a), .req_b(req_b),
    .req_ready(req_ready), .busy(busy), .rd_req(rd_req), .stall(stall),
    .hi(hi), .lo(lo)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int lat_of(input bit dv, input bit dw);
    if (!dv) return dw ? 20 : 10;
    return dw ? 133 : 69;
  endfunction

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  // expected hi/lo from the requirement text
  task automatic model(input bit dv, input bit sg, input bit dw,
                       input logic [63:0] a, input logic [63:0] b,
                       output logic [63:0] eh, output logic [63:0] el);
    logic [63:0]  as_, bs_, am, bm, q, r;
    logic [127:0] p;
    bit na, nb;
    as_ = dw ? a : sx32(a[31:0]);
    bs_ = dw ? b : sx32(b[31:0]);
    na  = sg && as_[63];
    nb  = sg && bs_[63];
    am  = na ? -as_ : as_;
    bm  = nb ? -bs_ : bs_;
    if (!dw) begin am[63:32] = '0; bm[63:32] = '0; end
    if (!dv) begin
      p = {64'b0, am} * {64'b0, bm};
      if (na ^ nb) p = -p;
      if (dw) begin eh = p[127:64]; el = p[63:0]; end
      else    begin eh = sx32(p[63:32]); el = sx32(p[31:0]); end
    end else begin
      if (bm == 0) begin q = '1; r = am; end
      else begin q = am / bm; r = am % bm; end
      if (dw == 0) q[63:32] = '0;
      if (na ^ nb) q = -q;
      if (na) r = -r;
      if (dw) begin eh = r; el = q; end
      else    begin eh = sx32(r[31:0]); el = sx32(q[31:0]); end
    end
  endtask

  task automatic run_op(input bit dv, input bit sg, input bit dw,
                        input logic [63:0] a, input logic [63:0] b,
                        input bit check_val, input string tag);
    logic [63:0] eh, el;
    int n;
    model(dv, sg, dw, a, b, eh, el);
    @(negedge clk);
    chk("R1 ready while idle", {63'b0, req_ready}, 64'd1);
    req_div = dv; req_signed = sg; req_dword = dw; req_a = a; req_b = b;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 busy after accept", {63'b0, busy}, 64'd1);
    n = 0;
    while (busy && n < 400) begin
      n++;
      if (n == 2) begin
        // competing request and early read in the same cycle
        req_valid = 1'b1; req_div = ~dv; req_dword = ~dw;
        req_a = ~a; req_b = b + 64'd3; rd_req = 1'b1;
        #1;
        chk("R4 stall while busy", {63'b0, stall}, 64'd1);
        chk("R3 not ready while busy", {63'b0, req_ready}, 64'd0);
      end else begin
        req_valid = 1'b0; rd_req = 1'b0;
      end
      @(negedge clk);
    end
    chk({"R2 latency ", tag}, 64'(n), 64'(lat_of(dv, dw)));
    if (check_val) begin
      chk({"R5/R6 hi ", tag}, hi, eh);
      chk({"R5/R6 lo ", tag}, lo, el);
    end
    rd_req = 1'b1;
    #1;
    chk("R4 no stall when done", {63'b0, stall}, 64'd0);
    rd_req = 1'b0;
    @(negedge clk);
    chk("R3 refused request not started", {63'b0, busy}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    logic [63:0] h0, l0, ra, rb;
    rst_n = 1'b0; req_valid = 1'b0; req_div = 1'b0; req_signed = 1'b0;
    req_dword = 1'b0; req_a = '0; req_b = '0; rd_req = 1'b0;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset busy", {63'b0, busy}, 64'd0);
    chk("R9 reset hi", hi, 64'd0);
    chk("R9 reset lo", lo, 64'd0);

    // directed corners
    run_op(0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1, "R5 umul max dword");
    run_op(0, 1, 0, 64'hDEAD_0000_FFFF_FFFF, 64'h1234_5678_FFFF_FFFF, 1, "R7 smul -1*-1 word");
    run_op(0, 0, 0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0002, 1, "R7 umul word sext");
    run_op(0, 1, 1, 64'hFFFF_FFFF_FFFF_FFF9, 64'd3, 1, "R5 smul neg dword");
    run_op(1, 1, 0, 64'hFFFF_FFFF_FFFF_FFF9, 64'd2, 1, "R6 -7/2 word");
    run_op(1, 1, 1, 64'd7, 64'hFFFF_FFFF_FFFF_FFFE, 1, "R6 7/-2 dword");
    run_op(1, 0, 0, 64'h0000_0000_FFFF_FFF9, 64'd2, 1, "R7 udiv word");
    run_op(1, 1, 1, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R10 dword");
    chk("R10 dword lo", lo, 64'h8000_0000_0000_0000);
    chk("R10 dword hi", hi, 64'd0);
    run_op(1, 1, 0, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 0, "R10 word");
    chk("R10 word lo", lo, 64'hFFFF_FFFF_8000_0000);
    chk("R10 word hi", hi, 64'd0);
    run_op(1, 0, 1, 64'h0123_4567_89AB_CDEF, 64'd0, 0, "R8 udiv0 dword");
    chk("R8 dword lo", lo, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R8 dword hi", hi, 64'h0123_4567_89AB_CDEF);
    run_op(1, 0, 0, 64'h5555_0000_8765_4321, 64'hAAAA_0000_0000_0000, 0, "R8 udiv0 word");
    chk("R8 word lo", lo, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R8 word hi", hi, 64'hFFFF_FFFF_8765_4321);
    run_op(1, 1, 1, 64'hFFFF_FFFF_FFFF_FF00, 64'd0, 0, "R8 sdiv0 latency");

    // results hold while idle
    h0 = hi; l0 = lo;
    repeat (5) @(negedge clk);
    chk("R9 hi held", hi, h0);
    chk("R9 lo held", lo, l0);

    // constrained random
    for (int i = 0; i < 40; i++) begin
      bit dv, sg, dw;
      dv = 1'($urandom());
      sg = 1'($urandom());
      dw = 1'($urandom());
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      if ((i % 4) == 1) rb = 64'($urandom_range(1, 17));
      if ((i % 5) == 2) ra[63:8] = {56{ra[63]}};
      if (dv && (dw ? (rb == 0) : (rb[31:0] == 0))) rb = 64'd5;
      run_op(dv, sg, dw, ra, rb, 1, "R7 random");
    end

    report();
    $finish;
  end
endmodule